// File: doc/BRIEF.md
# Paired Clock Output Divider Matrix

This block generates six output pairs from one fast system clock. The system clock oversamples two incoming clock levels: a PLL-domain clock and a reference clock. A global bit picks which of the two feeds a shared bank of dividers. Each pair carries a 3-bit source code that connects it to one of the following:

- the raw reference level,
- one of the divider waves (/1, /2, /3, /4, /X or /2X),
- the lock status input.

Each pair also has an enable and an invert bit that acts on its even member. The block is meant to sit behind a clock-generation core. The only configuration it needs is the per-pair fields, the divider-source bit and the programmable value X.

Time is counted in source cycles. A divided wave advances on each rising edge of the selected source level. For a ratio n of 2 or more, the wave is high for floor(n/2) source cycles and low for the rest of the n cycles. The /1 wave is the selected source level delayed by one system clock. All dividers restart together from count zero on reset, on any change of the effective X and on any change of the divider-source bit. This restart keeps their rising edges aligned.

Top module: `paired_clk_matrix`

## Requirements
- R1: Source code 000 drives the pair's odd output with the `ref_lvl` value sampled at the previous system clock edge (one register of latency).
- R2: Codes 001, 010, 011 and 100 select ratios 1, 2, 3 and 4. For ratio n of 2 or more, the output repeats every n source cycles and is high for floor(n/2) of them. Ratio 1 reproduces the source level's own period and high time.
- R3: Code 101 selects ratio X and code 110 selects ratio 2X, with the same waveform rule as R2. X is the 7-bit `x_val` input.
- R4: An `x_val` below 5 is treated as 5.
- R5: `div_from_ref` = 0 clocks the dividers from `pll_lvl`; `div_from_ref` = 1 clocks them from `ref_lvl`.
- R6: Code 111 makes the pair a lock indicator. With invert clear, both outputs equal `lock_in`. With invert set, the even output is the complement of `lock_in` and the odd output equals it.
- R7: With the pair's invert bit set, the even output is the complement of the odd output. With it clear, the two outputs are equal.
- R8: A pair whose enable bit is 0 drives both outputs low, whatever its code, invert bit or inputs.
- R9: Every rising edge of the /4 wave falls on a rising edge of the /2 wave. Every rising edge of the /2X wave falls on a rising edge of the /X wave.
- R10: A change of the effective X or of `div_from_ref` restarts all dividers from count zero. The new ratio is in force from the following period, and the R9 alignment holds after the change.
- R11: While `rst_n` is low, every output is low from the first clock edge on.
- R12: Each pair takes its code from bits [3p+2:3p] of `pair_sel` (p = 0..5), independently of the other pairs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples both source levels |
| rst_n | input | 1 | Synchronous active-low reset |
| pll_lvl | input | 1 | Sampled level of the PLL-domain clock |
| ref_lvl | input | 1 | Sampled level of the reference clock |
| div_from_ref | input | 1 | Divider source: 0 = PLL level, 1 = reference level |
| x_val | input | 7 | Programmable ratio X (values below 5 act as 5) |
| lock_in | input | 1 | PLL lock status |
| pair_sel | input | 18 | Per-pair 3-bit source code, pair p at bits [3p+2:3p] |
| pair_en | input | 6 | Per-pair enable |
| pair_inv | input | 6 | Per-pair invert of the even output |
| out_even | output | 6 | Even member of each pair |
| out_odd | output | 6 | Odd member of each pair |

## Verification
Several properties are checked on every cycle:

- the quiet state of disabled pairs,
- the complementary or equal relation between pair members,
- the lock indicator following its input,
- the counters staying inside their ratio,
- the rising-edge alignment of /4 with /2 and of /2X with /X,
- all divider waves starting high right after a restart.

Some behaviour only the bench's scenarios can show:

- the actual periods and high times for each code, source selection and X (including clamped values),
- the one-cycle passthrough of the reference,
- the switch to a new ratio after X changes mid-run.

// File: rtl/pcm_pkg.sv
package pcm_pkg;

  localparam int PCM_XW    = 7;            // width of programmable X
  localparam int PCM_CW    = PCM_XW + 2;   // counter width, holds 2*X
  localparam int PCM_CODEW = 3;
  localparam int PCM_NCODE = 1 << PCM_CODEW;
  localparam logic [PCM_XW-1:0] PCM_XMIN = 7'd5;

  typedef enum logic [PCM_CODEW-1:0] {
    SRC_REF  = 3'd0,
    SRC_D1   = 3'd1,
    SRC_D2   = 3'd2,
    SRC_D3   = 3'd3,
    SRC_D4   = 3'd4,
    SRC_DX   = 3'd5,
    SRC_D2X  = 3'd6,
    SRC_LOCK = 3'd7
  } pair_src_e;

  // values below the legal floor act as the floor
  function automatic logic [PCM_XW-1:0] clamp_x(input logic [PCM_XW-1:0] x);
    return (x < PCM_XMIN) ? PCM_XMIN : x;
  endfunction

  // division ratio for a divider code, given an already clamped X
  function automatic logic [PCM_CW-1:0] ratio_for_code(input int code,
                                                        input logic [PCM_XW-1:0] x);
    case (code)
      2:       return PCM_CW'(2);
      3:       return PCM_CW'(3);
      4:       return PCM_CW'(4);
      5:       return {2'b00, x};
      6:       return {1'b0, x, 1'b0};
      default: return PCM_CW'(1);
    endcase
  endfunction

  // number of source cycles the wave stays high within one period
  function automatic logic [PCM_CW-1:0] high_len(input logic [PCM_CW-1:0] n);
    return n >> 1;
  endfunction

endpackage

// File: rtl/pcm_src_tick.sv
module pcm_src_tick (
  input  logic clk,
  input  logic rst_n,
  input  logic pll_lvl,
  input  logic ref_lvl,
  input  logic use_ref,
  output logic tick,
  output logic lvl_q
);
  logic sel_lvl;

  assign sel_lvl = use_ref ? ref_lvl : pll_lvl;

  always_ff @(posedge clk) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= sel_lvl;
  end

  // a rising edge of the chosen source advances the dividers
  assign tick = sel_lvl & ~lvl_q;

endmodule

// File: rtl/pcm_divider.sv
module pcm_divider #(
  parameter int CW = pcm_pkg::PCM_CW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          tick,
  input  logic [CW-1:0] ratio,
  output logic          wave
);
  logic [CW-1:0] cnt;
  logic          at_last;

  assign at_last = (cnt == ratio - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n || restart)  cnt <= '0;
    else if (tick)          cnt <= at_last ? '0 : cnt + 1'b1;
  end

  assign wave = (cnt < pcm_pkg::high_len(ratio));

  // R2: the count never leaves the range of its ratio
  assert_cnt_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt < ratio));

endmodule

// File: rtl/pcm_div_bank.sv
module pcm_div_bank
  import pcm_pkg::*;
#(
  parameter int XW = PCM_XW,
  parameter int CW = PCM_CW,
  parameter int NCODE = PCM_NCODE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pll_lvl,
  input  logic             ref_lvl,
  input  logic             use_ref,
  input  logic [XW-1:0]    x_val,
  output logic [NCODE-1:0] div_wave
);
  localparam int FIRST_CNT_CODE = 2;
  localparam int LAST_CNT_CODE  = 6;

  logic          tick;
  logic          lvl_q;
  logic [XW-1:0] x_eff;
  logic [XW-1:0] x_q;
  logic          use_ref_q;
  logic          cfg_chg;

  pcm_src_tick u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .pll_lvl (pll_lvl),
    .ref_lvl (ref_lvl),
    .use_ref (use_ref),
    .tick    (tick),
    .lvl_q   (lvl_q)
  );

  assign x_eff   = clamp_x(x_val);
  assign cfg_chg = (x_eff != x_q) || (use_ref != use_ref_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x_q       <= x_eff;
      use_ref_q <= use_ref;
    end else begin
      x_q       <= x_eff;
      use_ref_q <= use_ref;
    end
  end

  assign div_wave[0] = 1'b0;
  assign div_wave[1] = lvl_q;
  assign div_wave[NCODE-1] = 1'b0;

  for (genvar c = FIRST_CNT_CODE; c <= LAST_CNT_CODE; c++) begin : g_div
    pcm_divider #(.CW(CW)) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (cfg_chg),
      .tick    (tick),
      .ratio   (ratio_for_code(c, x_q)),
      .wave    (div_wave[c])
    );
  end

  // R9: /4 edges sit on /2 edges, /2X edges sit on /X edges
  assert_edge_align_4_2_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(div_wave[4]) && !$past(cfg_chg)) |-> $rose(div_wave[2]));
  assert_edge_align_2x_x_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(div_wave[6]) && !$past(cfg_chg)) |-> $rose(div_wave[5]));
  // R10: a configuration change leaves every counted wave at the start of its period
  assert_restart_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_chg |=> (&div_wave[LAST_CNT_CODE:FIRST_CNT_CODE]));

endmodule

// File: rtl/pcm_pair_out.sv
module pcm_pair_out
  import pcm_pkg::*;
#(
  parameter int NCODE = PCM_NCODE,
  parameter int CODEW = PCM_CODEW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CODEW-1:0] code,
  input  logic             en,
  input  logic             inv,
  input  logic             ref_lvl,
  input  logic             lock_in,
  input  logic [NCODE-1:0] div_wave,
  output logic             even_q,
  output logic             odd_q
);
  logic      base;
  pair_src_e src;

  assign src = pair_src_e'(code);

  always_comb begin
    case (src)
      SRC_REF:  base = ref_lvl;
      SRC_LOCK: base = lock_in;
      default:  base = div_wave[code];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      even_q <= 1'b0;
      odd_q  <= 1'b0;
    end else begin
      even_q <= en & (base ^ inv);
      odd_q  <= en & base;
    end
  end

  // R8: a disabled pair is quiet
  assert_quiet_when_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!even_q && !odd_q));
  // R7: invert makes the pair complementary, otherwise the members match
  assert_complement_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && inv) |=> (even_q != odd_q));
  assert_members_equal_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !inv) |=> (even_q == odd_q));
  // R6: the lock indicator follows the lock input
  assert_lock_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && src == SRC_LOCK) |=> (odd_q == $past(lock_in)));

endmodule

// File: rtl/paired_clk_matrix.sv
module paired_clk_matrix
  import pcm_pkg::*;
#(
  parameter int NPAIRS = 6,
  parameter int XW     = PCM_XW,
  localparam int CODEW = PCM_CODEW,
  localparam int SELW  = NPAIRS * CODEW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pll_lvl,
  input  logic              ref_lvl,
  input  logic              div_from_ref,
  input  logic [XW-1:0]     x_val,
  input  logic              lock_in,
  input  logic [SELW-1:0]   pair_sel,
  input  logic [NPAIRS-1:0] pair_en,
  input  logic [NPAIRS-1:0] pair_inv,
  output logic [NPAIRS-1:0] out_even,
  output logic [NPAIRS-1:0] out_odd
);
  logic [PCM_NCODE-1:0] div_wave;

  pcm_div_bank #(.XW(XW), .CW(XW + 2), .NCODE(PCM_NCODE)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .pll_lvl  (pll_lvl),
    .ref_lvl  (ref_lvl),
    .use_ref  (div_from_ref),
    .x_val    (x_val),
    .div_wave (div_wave)
  );

  for (genvar p = 0; p < NPAIRS; p++) begin : g_pair
    pcm_pair_out #(.NCODE(PCM_NCODE), .CODEW(CODEW)) u_pair (
      .clk      (clk),
      .rst_n    (rst_n),
      .code     (pair_sel[p*CODEW +: CODEW]),
      .en       (pair_en[p]),
      .inv      (pair_inv[p]),
      .ref_lvl  (ref_lvl),
      .lock_in  (lock_in),
      .div_wave (div_wave),
      .even_q   (out_even[p]),
      .odd_q    (out_odd[p])
    );
  end

  // R11: outputs are low while reset is held
  assert_reset_quiet_R11: assert property (@(posedge clk)
    !rst_n |=> (out_even == '0 && out_odd == '0));

endmodule

// File: tb/paired_clk_matrix_test.sv
module paired_clk_matrix_test;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pll_lvl = 1'b0, ref_lvl = 1'b0, div_from_ref = 1'b0, lock_in = 1'b0;
  logic [6:0] x_val = 7'd5;
  logic [3*NP-1:0] pair_sel = '0;
  logic [NP-1:0] pair_en = '0, pair_inv = '0;
  logic [NP-1:0] out_even, out_odd;

  int hp_pll = 1, hp_ref = 1, pc = 0, rc = 0;
  bit ref_rand = 1'b0;
  int n_chk = 0, n_bad = 0;

  paired_clk_matrix uut (
    .clk(clk), .rst_n(rst_n), .pll_lvl(pll_lvl), .ref_lvl(ref_lvl),
    .div_from_ref(div_from_ref), .x_val(x_val), .lock_in(lock_in),
    .pair_sel(pair_sel), .pair_en(pair_en), .pair_inv(pair_inv),
    .out_even(out_even), .out_odd(out_odd)
  );

  initial forever #(CLK_PERIOD/2) clk = ~clk;

  // source level generators, driven a quarter period after the rising edge
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    pc = pc + 1;
    if (pc >= hp_pll) begin pc = 0; pll_lvl = ~pll_lvl; end
    if (ref_rand) ref_lvl = 1'($urandom_range(0, 1));
    else begin
      rc = rc + 1;
      if (rc >= hp_ref) begin rc = 0; ref_lvl = ~ref_lvl; end
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish (actual timeout, expected completion)");
    summary();
    $finish;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int xe(input int x);
    return (x < 5) ? 5 : x;
  endfunction
  function automatic int ratio_of(input int code, input int x);
    if (code == 5) return xe(x);
    if (code == 6) return 2 * xe(x);
    return code;
  endfunction
  function automatic int exp_hi(input int code, input int x, input int h);
    int n = ratio_of(code, x);
    return (n == 1) ? h : 2 * h * (n / 2);
  endfunction
  function automatic int exp_per(input int code, input int x, input int h);
    return 2 * h * ratio_of(code, x);
  endfunction

  task automatic set_pair(input int p, input int code, input bit en, input bit inv);
    pair_sel[3*p +: 3] = 3'(code);
    pair_en[p] = en;
    pair_inv[p] = inv;
  endtask

  task automatic measure(input int p, output int hi, output int per);
    int t = 0;
    hi = 0; per = 0;
    while (out_odd[p] !== 1'b0 && t < 3000) begin @(negedge clk); t++; end
    while (out_odd[p] !== 1'b1 && t < 3000) begin @(negedge clk); t++; end
    while (out_odd[p] === 1'b1 && t < 3000) begin hi++; per++; @(negedge clk); t++; end
    while (out_odd[p] === 1'b0 && t < 3000) begin per++; @(negedge clk); t++; end
    if (t >= 3000) per = -1;
  endtask

  task automatic measure2(input int p, output int hi, output int per);
    repeat (6) @(negedge clk);
    measure(p, hi, per);
    measure(p, hi, per);
  endtask

  initial begin
    int hi, per, bad, code, x, h, p;
    logic [NP-1:0] prev;
    void'($urandom(32'd20240611));

    // R11: reset holds everything low
    for (int q = 0; q < NP; q++) set_pair(q, 7, 1'b1, 1'b1);
    lock_in = 1'b1;
    repeat (4) @(negedge clk);
    chk(out_even == 0 && out_odd == 0, "R11 reset", int'({out_even, out_odd}), 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R6: lock indicator both polarities
    set_pair(3, 7, 1'b1, 1'b0); lock_in = 1'b1;
    repeat (2) @(negedge clk);
    chk(out_even[3] == 1 && out_odd[3] == 1, "R6 lock noninv", int'({out_even[3], out_odd[3]}), 3);
    pair_inv[3] = 1'b1;
    repeat (2) @(negedge clk);
    chk(out_even[3] == 0 && out_odd[3] == 1, "R6 lock inv locked", int'({out_even[3], out_odd[3]}), 1);
    lock_in = 1'b0;
    repeat (2) @(negedge clk);
    chk(out_even[3] == 1 && out_odd[3] == 0, "R6 lock inv unlocked", int'({out_even[3], out_odd[3]}), 2);

    // R1 passthrough and R8 quiet pair, with a random reference
    ref_rand = 1'b1;
    set_pair(2, 0, 1'b1, 1'b0);
    set_pair(4, 0, 1'b0, 1'b1);
    @(negedge clk);
    bad = 0;
    begin
      logic last_ref;
      int quiet_bad = 0;
      last_ref = ref_lvl;
      for (int i = 0; i < 60; i++) begin
        @(negedge clk);
        if (out_odd[2] !== last_ref) bad++;
        if (out_odd[4] !== 1'b0 || out_even[4] !== 1'b0) quiet_bad++;
        last_ref = ref_lvl;
      end
      chk(bad == 0, "R1 passthrough", bad, 0);
      chk(quiet_bad == 0, "R8 disabled pair quiet", quiet_bad, 0);
    end
    ref_rand = 1'b0;

    // R4: X below 5 clamps to 5
    div_from_ref = 1'b0; hp_pll = 1; x_val = 7'd2;
    set_pair(0, 5, 1'b1, 1'b0);
    measure2(0, hi, per);
    chk(per == exp_per(5, 2, 1) && hi == exp_hi(5, 2, 1), "R4 clamp X=2", per * 1000 + hi,
        exp_per(5, 2, 1) * 1000 + exp_hi(5, 2, 1));

    // R5: source select changes the timebase
    hp_pll = 1; hp_ref = 3;
    set_pair(0, 2, 1'b1, 1'b0);
    div_from_ref = 1'b0;
    measure2(0, hi, per);
    chk(per == 4, "R5 pll source /2", per, 4);
    div_from_ref = 1'b1;
    measure2(0, hi, per);
    chk(per == 12 && hi == 6, "R5 ref source /2", per * 1000 + hi, 12006);
    div_from_ref = 1'b0;

    // R12: all pairs independent, distinct codes
    hp_pll = 1; x_val = 7'd6;
    for (int q = 0; q < NP; q++) set_pair(q, q + 1, 1'b1, 1'b0);
    for (int q = 0; q < NP; q++) begin
      measure2(q, hi, per);
      chk(per == exp_per(q + 1, 6, 1) && hi == exp_hi(q + 1, 6, 1), "R12 pair code",
          per * 1000 + hi, exp_per(q + 1, 6, 1) * 1000 + exp_hi(q + 1, 6, 1));
    end

    // R2/R3/R5/R7: constrained random configurations
    for (int tr = 0; tr < 16; tr++) begin
      h = $urandom_range(1, 3);
      x = $urandom_range(0, 14);
      div_from_ref = 1'($urandom_range(0, 1));
      hp_pll = h; hp_ref = h;
      x_val = 7'(x);
      for (int q = 0; q < NP; q++)
        set_pair(q, $urandom_range(1, 6), 1'b1, 1'($urandom_range(0, 1)));
      p = tr % NP;
      code = int'(pair_sel[3*p +: 3]);
      measure2(p, hi, per);
      chk(per == exp_per(code, x, h) && hi == exp_hi(code, x, h),
          (code >= 5) ? "R3 X ratio" : "R2 fixed ratio",
          per * 1000 + hi, exp_per(code, x, h) * 1000 + exp_hi(code, x, h));
      bad = 0;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        for (int q = 0; q < NP; q++)
          if ((out_even[q] ^ out_odd[q]) !== pair_inv[q]) bad++;
      end
      chk(bad == 0, "R7 pair relation", bad, 0);
    end

    // R9/R10: alignment and restart across an X change
    div_from_ref = 1'b0; hp_pll = 1; x_val = 7'd7;
    set_pair(0, 5, 1'b1, 1'b0);
    set_pair(1, 6, 1'b1, 1'b0);
    set_pair(2, 2, 1'b1, 1'b0);
    set_pair(3, 4, 1'b1, 1'b0);
    repeat (5) @(negedge clk);
    prev = out_odd;
    bad = 0;
    for (int i = 0; i < 800; i++) begin
      @(negedge clk);
      if (i == 300) x_val = 7'd9;
      if (i < 300 || i > 305) begin
        if (out_odd[1] && !prev[1] && !(out_odd[0] && !prev[0])) bad++;
        if (out_odd[3] && !prev[3] && !(out_odd[2] && !prev[2])) bad++;
      end
      prev = out_odd;
    end
    chk(bad == 0, "R9 edge alignment across change", bad, 0);
    measure(0, hi, per);
    chk(per == 18 && hi == 8, "R10 new X after change", per * 1000 + hi, 18008);

    summary();
    $finish;
  end
endmodule